// File: doc/BRIEF.md
# Trap Entry Sequencer

This block applies the architectural state change a hart makes when it takes a trap, whether an exception or an interrupt. When the core raises a one-cycle trap request, it presents the cause code, an interrupt flag, the faulting address, the PC of the trapping instruction, the current privilege and status word, and the two delegation masks and two handler-base registers. The sequencer picks the handling level, supervisor or machine. It computes the new status word, the cause, EPC and trap-value words, the handler PC and the new privilege. All of these are registered together and appear in the following cycle.

The core's CSR file and fetch unit consume the results. When `trap_done` is high they load the results into the registers of the chosen level and redirect fetch to `nxt_pc`. On the same cycle `resv_clear` tells the load/store unit to drop any outstanding load reservation. The registered outputs hold their values until the next trap request.

Top module: `trap_entry_seq`

## Requirements
- R1: A trap targets supervisor level (`trap_to_s`=1) only when the current privilege is U (00) or S (01), the effective cause is below 32, and the delegation bit indexed by the cause is set. That bit comes from `irq_deleg` for interrupts and from `exc_deleg` for exceptions. In every other case the trap targets machine level.
- R2: On a supervisor-level trap, status bit 5 takes the old bit 1 and bit 8 takes bit 0 of the old privilege. Bit 1 is cleared and `nxt_priv` becomes 01.
- R3: On a machine-level trap, status bit 7 takes the old bit 3 and bits 12:11 take the old privilege. Bit 3 is cleared and `nxt_priv` becomes 11. In both cases every other status bit is copied from `cur_status` unchanged.
- R4: `nxt_cause` holds the effective cause, zero-extended, in its low bits. Bit 31 of `nxt_cause` is set for interrupts and clear for exceptions.
- R5: `nxt_epc` equals the `cur_pc` presented with the request.
- R6: `nxt_tval` equals `trap_badaddr` only for exceptions with cause 0, 1, 4, 5, 6, 7, 12, 13 or 15, which are the misaligned, access-fault and page-fault codes. For every other exception and for all interrupts it is 0.
- R7: An exception with cause 8 (environment call) is rewritten by privilege: it stays 8 from U, becomes 9 from S and becomes 11 from M. Delegation uses the rewritten code. An interrupt with code 8 is not rewritten.
- R8: `nxt_pc` is the selected handler base (`s_tvec` for supervisor, `m_tvec` for machine) with bits 1:0 cleared. When the trap is an interrupt and the base's bits 1:0 equal 01, 4×cause is added. Mode values 00, 10 and 11, and every exception, add nothing.
- R9: The results appear in the cycle after the clock edge that samples `trap_valid`. `trap_done` and `resv_clear` are high for exactly that one cycle. Without a request, all result outputs hold their values.
- R10: While reset is held, `trap_done`, `trap_to_s`, `resv_clear` and all data outputs are 0 and `nxt_priv` is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | One-cycle trap request |
| trap_async | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | 6 | Raw cause code |
| trap_badaddr | input | 32 | Faulting address for the trap-value word |
| cur_pc | input | 32 | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege (00 U, 01 S, 11 M) |
| cur_status | input | 32 | Current status word |
| exc_deleg | input | 32 | Exception delegation mask |
| irq_deleg | input | 32 | Interrupt delegation mask |
| s_tvec | input | 32 | Supervisor handler base and mode |
| m_tvec | input | 32 | Machine handler base and mode |
| trap_done | output | 1 | Results valid this cycle |
| trap_to_s | output | 1 | 1 = handled at supervisor level |
| nxt_status | output | 32 | Updated status word |
| nxt_cause | output | 32 | Cause word for the target level |
| nxt_epc | output | 32 | Exception PC for the target level |
| nxt_tval | output | 32 | Trap-value word for the target level |
| nxt_pc | output | 32 | Handler PC |
| nxt_priv | output | 2 | New privilege |
| resv_clear | output | 1 | Drop the load reservation |

## Verification
A wrong routing decision shows up in the very cycle `trap_done` rises. Both the privilege output and the saved-privilege field in the status word come out wrong, and the handler PC is drawn from the other base. A slip in the environment-call rewrite changes the cause word and can also flip the routing, because delegation is indexed by the rewritten code. Hold failures show up on the first idle cycle after a trap, as output changes while `trap_valid` is low. For these reasons, every result field is compared against a bench model in the cycle after each request, and again after an idle cycle.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPV  = 2'b01,
    PRIV_RSVD  = 2'b10,
    PRIV_MACH  = 2'b11
  } priv_e;

  // Status word field positions
  localparam int ST_S_EN      = 1;
  localparam int ST_M_EN      = 3;
  localparam int ST_S_PREV_EN = 5;
  localparam int ST_M_PREV_EN = 7;
  localparam int ST_S_PREV_PR = 8;
  localparam int ST_M_PREV_LO = 11;
  localparam int ST_M_PREV_HI = 12;

  // Environment call codes
  localparam int ENVCALL_USER = 8;
  localparam int ENVCALL_SUPV = 9;
  localparam int ENVCALL_MACH = 11;

  // Handler base mode that spreads interrupts by cause
  localparam logic [1:0] TVEC_SPREAD = 2'b01;

  // Exception codes that carry an address: 0,1,4,5,6,7,12,13,15
  localparam logic [31:0] ADDR_CODES = 32'h0000_B0F3;

endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_seq_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               is_async,
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic [1:0]         priv,
  input  logic [XLEN-1:0]    exc_deleg,
  input  logic [XLEN-1:0]    irq_deleg,
  output logic [CAUSE_W-1:0] eff_cause,
  output logic               to_s,
  output logic               keep_tval
);
  localparam int IDX_W = $clog2(XLEN);
  localparam int CW1   = CAUSE_W + 1;

  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic [XLEN-1:0]  deleg_vec;
  logic             low_priv;

  // Rewrite the environment-call code according to the trapping privilege
  always_comb begin
    eff_cause = cause_in;
    if (!is_async && (cause_in == CAUSE_W'(ENVCALL_USER))) begin
      case (priv_e'(priv))
        PRIV_MACH: eff_cause = CAUSE_W'(ENVCALL_MACH);
        PRIV_SUPV: eff_cause = CAUSE_W'(ENVCALL_SUPV);
        default:   eff_cause = CAUSE_W'(ENVCALL_USER);
      endcase
    end
  end

  always_comb begin
    idx       = eff_cause[IDX_W-1:0];
    in_range  = ({1'b0, eff_cause} < CW1'(XLEN));
    deleg_vec = is_async ? irq_deleg : exc_deleg;
    low_priv  = (priv == PRIV_USER) || (priv == PRIV_SUPV);
    to_s      = low_priv && in_range && deleg_vec[idx];
    keep_tval = !is_async && in_range && ADDR_CODES[idx];
  end

endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
  import trap_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] status_in,
  input  logic [1:0]      priv,
  input  logic            to_s,
  output logic [XLEN-1:0] status_out
);
  always_comb begin
    status_out = status_in;
    if (to_s) begin
      status_out[ST_S_PREV_EN] = status_in[ST_S_EN];
      status_out[ST_S_PREV_PR] = priv[0];
      status_out[ST_S_EN]      = 1'b0;
    end else begin
      status_out[ST_M_PREV_EN]               = status_in[ST_M_EN];
      status_out[ST_M_PREV_HI:ST_M_PREV_LO]  = priv;
      status_out[ST_M_EN]                    = 1'b0;
    end
  end
endmodule

// File: rtl/trap_vector.sv
module trap_vector
  import trap_seq_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic [XLEN-1:0]    tvec,
  input  logic               is_async,
  input  logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    handler_pc
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  always_comb begin
    base   = {tvec[XLEN-1:2], 2'b00};
    offset = XLEN'(cause) << 2;
    if (is_async && (tvec[1:0] == TVEC_SPREAD)) handler_pc = base + offset;
    else                                         handler_pc = base;
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_valid,
  input  logic               trap_async,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_badaddr,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [1:0]         cur_priv,
  input  logic [XLEN-1:0]    cur_status,
  input  logic [XLEN-1:0]    exc_deleg,
  input  logic [XLEN-1:0]    irq_deleg,
  input  logic [XLEN-1:0]    s_tvec,
  input  logic [XLEN-1:0]    m_tvec,
  output logic               trap_done,
  output logic               trap_to_s,
  output logic [XLEN-1:0]    nxt_status,
  output logic [XLEN-1:0]    nxt_cause,
  output logic [XLEN-1:0]    nxt_epc,
  output logic [XLEN-1:0]    nxt_tval,
  output logic [XLEN-1:0]    nxt_pc,
  output logic [1:0]         nxt_priv,
  output logic               resv_clear
);
  localparam int PAD_W = XLEN - 1 - CAUSE_W;

  logic [CAUSE_W-1:0] eff_cause;
  logic               route_s;
  logic               keep_tval;
  logic [XLEN-1:0]    status_d;
  logic [XLEN-1:0]    sel_tvec;
  logic [XLEN-1:0]    pc_d;
  logic [XLEN-1:0]    cause_d;
  logic [XLEN-1:0]    tval_d;
  logic [1:0]         priv_d;

  trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) route_i (
    .is_async  (trap_async),
    .cause_in  (trap_cause),
    .priv      (cur_priv),
    .exc_deleg (exc_deleg),
    .irq_deleg (irq_deleg),
    .eff_cause (eff_cause),
    .to_s      (route_s),
    .keep_tval (keep_tval)
  );

  trap_status_upd #(.XLEN(XLEN)) status_i (
    .status_in  (cur_status),
    .priv       (cur_priv),
    .to_s       (route_s),
    .status_out (status_d)
  );

  assign sel_tvec = route_s ? s_tvec : m_tvec;

  trap_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) vector_i (
    .tvec       (sel_tvec),
    .is_async   (trap_async),
    .cause      (eff_cause),
    .handler_pc (pc_d)
  );

  // Next-state values
  always_comb begin
    cause_d = {trap_async, {PAD_W{1'b0}}, eff_cause};
    tval_d  = keep_tval ? trap_badaddr : '0;
    priv_d  = route_s ? PRIV_SUPV : PRIV_MACH;
  end

  // Strobes: one cycle per request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_done  <= 1'b0;
      resv_clear <= 1'b0;
    end else begin
      trap_done  <= trap_valid;
      resv_clear <= trap_valid;
    end
  end

  // Result registers, loaded only on a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_to_s  <= 1'b0;
      nxt_status <= '0;
      nxt_cause  <= '0;
      nxt_epc    <= '0;
      nxt_tval   <= '0;
      nxt_pc     <= '0;
      nxt_priv   <= PRIV_MACH;
    end else if (trap_valid) begin
      trap_to_s  <= route_s;
      nxt_status <= status_d;
      nxt_cause  <= cause_d;
      nxt_epc    <= cur_pc;
      nxt_tval   <= tval_d;
      nxt_pc     <= pc_d;
      nxt_priv   <= priv_d;
    end
  end

endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_valid,
  input logic            trap_async,
  input logic [1:0]      cur_priv,
  input logic            trap_done,
  input logic            trap_to_s,
  input logic [XLEN-1:0] nxt_status,
  input logic [XLEN-1:0] nxt_cause,
  input logic [XLEN-1:0] nxt_pc,
  input logic [1:0]      nxt_priv,
  input logic            resv_clear
);
  assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> trap_done);
  assert_no_spurious_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> !trap_done);
  assert_resv_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_done |-> resv_clear);
  assert_s_needs_low_priv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_done && trap_to_s) |-> ($past(cur_priv) <= 2'b01));
  assert_s_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_done && trap_to_s) |-> (!nxt_status[1] && nxt_status[8] == $past(cur_priv[0])
                                  && nxt_priv == 2'b01));
  assert_m_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_done && !trap_to_s) |-> (!nxt_status[3] && nxt_status[12:11] == $past(cur_priv)
                                   && nxt_priv == 2'b11));
  assert_cause_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_done |-> (nxt_cause[XLEN-1] == $past(trap_async)));
  assert_pc_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_done |-> (nxt_pc[1:0] == 2'b00));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> ($stable(nxt_pc) && $stable(nxt_cause) && $stable(nxt_status)));
endmodule

bind trap_entry_seq trap_entry_seq_chk #(.XLEN(XLEN)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .trap_valid (trap_valid),
  .trap_async (trap_async),
  .cur_priv   (cur_priv),
  .trap_done  (trap_done),
  .trap_to_s  (trap_to_s),
  .nxt_status (nxt_status),
  .nxt_cause  (nxt_cause),
  .nxt_pc     (nxt_pc),
  .nxt_priv   (nxt_priv),
  .resv_clear (resv_clear)
);

// File: tb/trap_entry_seq_tb.sv
module trap_entry_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int CW   = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          trap_valid, trap_async;
  logic [CW-1:0] trap_cause;
  logic [31:0]   trap_badaddr, cur_pc, cur_status, exc_deleg, irq_deleg, s_tvec, m_tvec;
  logic [1:0]    cur_priv;
  logic          trap_done, trap_to_s, resv_clear;
  logic [31:0]   nxt_status, nxt_cause, nxt_epc, nxt_tval, nxt_pc;
  logic [1:0]    nxt_priv;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_seq #(.XLEN(XLEN), .CAUSE_W(CW)) dut_i (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Bench reference model built from the requirement text
  logic        e_s;
  logic [31:0] e_status, e_cause, e_tval, e_pc, e_epc;
  logic [1:0]  e_priv;

  task automatic model();
    int c;
    bit addr_code;
    logic [31:0] dv, tv;
    c = int'(trap_cause);
    if (!trap_async && c == 8) c = (cur_priv == 2'b11) ? 11 : (cur_priv == 2'b01) ? 9 : 8;  // R7
    dv = trap_async ? irq_deleg : exc_deleg;
    e_s = (cur_priv == 2'b00 || cur_priv == 2'b01) && c < 32 && dv[c % 32];          // R1
    e_status = cur_status;
    if (e_s) begin
      e_status[5] = cur_status[1]; e_status[8] = cur_priv[0]; e_status[1] = 1'b0;    // R2
      e_priv = 2'b01;
    end else begin
      e_status[7] = cur_status[3]; e_status[12:11] = cur_priv; e_status[3] = 1'b0;   // R3
      e_priv = 2'b11;
    end
    e_cause = {trap_async, 31'(c)};                                                  // R4
    addr_code = (c == 0 || c == 1 || c == 4 || c == 5 || c == 6 || c == 7 ||
                 c == 12 || c == 13 || c == 15);
    e_tval = (!trap_async && addr_code) ? trap_badaddr : 32'h0;                      // R6
    tv = e_s ? s_tvec : m_tvec;
    e_pc = {tv[31:2], 2'b00};
    if (trap_async && tv[1:0] == 2'b01) e_pc = e_pc + 32'(c * 4);                   // R8
    e_epc = cur_pc;                                                                  // R5
  endtask

  task automatic fire_and_check(string tag);
    model();
    trap_valid = 1'b1;
    @(negedge clk);
    trap_valid = 1'b0;
    chk("R9", {tag, " done"}, 32'(trap_done), 32'd1);
    chk("R9", {tag, " resv_clear"}, 32'(resv_clear), 32'd1);
    chk("R1", {tag, " to_s"}, 32'(trap_to_s), 32'(e_s));
    chk("R2/R3", {tag, " status"}, nxt_status, e_status);
    chk("R2/R3", {tag, " priv"}, 32'(nxt_priv), 32'(e_priv));
    chk("R4", {tag, " cause"}, nxt_cause, e_cause);
    chk("R5", {tag, " epc"}, nxt_epc, e_epc);
    chk("R6", {tag, " tval"}, nxt_tval, e_tval);
    chk("R8", {tag, " pc"}, nxt_pc, e_pc);
  endtask

  task automatic randomize_inputs();
    int p;
    p = $urandom_range(0, 2);
    cur_priv     = (p == 2) ? 2'b11 : 2'(p);
    trap_async   = $urandom_range(0, 3) == 0;
    trap_cause   = ($urandom_range(0, 3) == 0) ? CW'($urandom_range(0, 63)) : CW'($urandom_range(0, 15));
    trap_badaddr = $urandom();
    cur_pc       = $urandom();
    cur_status   = $urandom();
    exc_deleg    = $urandom();
    irq_deleg    = $urandom();
    s_tvec       = $urandom();
    m_tvec       = $urandom();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0; trap_valid = 1'b0;
    randomize_inputs();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "done", 32'(trap_done), 32'd0);
    chk("R10", "resv", 32'(resv_clear), 32'd0);
    chk("R10", "priv", 32'(nxt_priv), 32'd3);
    chk("R10", "pc", nxt_pc, 32'd0);
    chk("R10", "status", nxt_status, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: environment call from each privilege, everything delegated
    exc_deleg = 32'hFFFF_FFFF; irq_deleg = 32'h0; trap_async = 1'b0; trap_cause = 6'd8;
    s_tvec = 32'h0000_4001; m_tvec = 32'h0000_8001; cur_status = 32'h0000_000A;
    cur_priv = 2'b00; fire_and_check("R7 ecall U");
    chk("R7", "ecall U code", nxt_cause, 32'd8);
    cur_priv = 2'b01; fire_and_check("R7 ecall S");
    chk("R7", "ecall S code", nxt_cause, 32'd9);
    cur_priv = 2'b11; fire_and_check("R7 ecall M");
    chk("R7", "ecall M code", nxt_cause, 32'd11);
    chk("R1", "ecall M goes to M", 32'(trap_to_s), 32'd0);

    // R1: out-of-range cause never delegated
    trap_async = 1'b1; irq_deleg = 32'hFFFF_FFFF; cur_priv = 2'b00; trap_cause = 6'd40;
    fire_and_check("R1 cause40");
    chk("R1", "cause40 to M", 32'(trap_to_s), 32'd0);

    // R8: spread handler, interrupt 5 to machine
    irq_deleg = 32'h0; trap_cause = 6'd5; m_tvec = 32'h1000_0001;
    fire_and_check("R8 spread");
    chk("R8", "spread pc", nxt_pc, 32'h1000_0014);
    m_tvec = 32'h1000_0003; fire_and_check("R8 mode3");
    chk("R8", "mode3 pc", nxt_pc, 32'h1000_0000);
    trap_async = 1'b0; m_tvec = 32'h1000_0001; exc_deleg = 32'h0;
    fire_and_check("R8 sync");
    chk("R8", "sync no offset", nxt_pc, 32'h1000_0000);

    // R6: tval kept for load page fault, zero for illegal op
    trap_cause = 6'd13; trap_badaddr = 32'hDEAD_BEEF; fire_and_check("R6 pf");
    chk("R6", "pf tval", nxt_tval, 32'hDEAD_BEEF);
    trap_cause = 6'd2; fire_and_check("R6 ill");
    chk("R6", "ill tval", nxt_tval, 32'h0);

    // R9: idle cycle holds results even when inputs move
    cur_pc = 32'h1234_5678; m_tvec = 32'h0; cur_status = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R9", "idle done", 32'(trap_done), 32'd0);
    chk("R9", "idle pc hold", nxt_pc, e_pc);
    chk("R9", "idle epc hold", nxt_epc, e_epc);
    chk("R9", "idle status hold", nxt_status, e_status);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      randomize_inputs();
      fire_and_check("rand");
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule